// File: doc/BRIEF.md
# Four-Line External Interrupt Sense Unit

This block watches four dedicated external interrupt pins. Software chooses per line whether that pin should request service on a falling edge, on a rising edge, or for as long as it is held low. It also chooses whether the line is enabled. Edge detection runs on the I/O clock. A detected edge latches a sticky flag, which software clears by writing a one to it. Low-level sensing works differently. Its request follows the synchronized pin directly, and a separate purely combinational path drives a wake output, so the block can rouse a sleeping system even while the I/O clock is stopped.

The unit has no data stream, so every port is a plain control or status pin and there is no back-pressure. The clear strobe is a one-cycle write-one-to-clear pulse per line. The request outputs are level signals for a downstream priority stage. The wake output goes to the power controller. If a low pulse ends before the system has finished waking, the wake has still happened, but no request is left pending.

Top module: `ext_irq_sense`

## Requirements
- R1: While reset is asserted and right after it, `flag_o` and `req_o` are all zero.
- R2: The per-line 2-bit sense field at `mode_i[2i+1:2i]` is encoded as follows: 00 = low level, 01 = reserved, 10 = falling edge, 11 = rising edge. A line in the reserved mode never sets its flag, never requests and never wakes.
- R3: In falling mode, a high-to-low pin change sets the line's flag on the third rising clock edge after the change. This allows two synchronizer stages and one flag register. A rising change does not set the flag.
- R4: In rising mode, a low-to-high pin change sets the flag with the same latency. A falling change does not set the flag.
- R5: A flag stays set until a cycle in which its bit of `flag_clr_i` is 1, and is zero after that edge. If a set and a clear fall on the same edge, the flag ends up set.
- R6: No edge is recognized while `clk_io_en_i` is 0. An edge that happens entirely while it is 0 leaves no flag after it returns to 1.
- R7: In level mode, `req_o[i]` is 1 exactly while the two-stage synchronized pin is low and the line is enabled. It is 1 two rising edges after the pin falls, and 0 two edges after the pin rises. Level mode never sets the flag.
- R8: `wake_o` is 1 combinationally, with no clock, whenever any enabled line in level mode has its raw pin low.
- R9: A low pulse seen only by the wake path, for example one that ends while the clock is stopped, raises `wake_o` but leaves neither a request nor a flag.
- R10: A line whose enable is 0 does not set its flag, does not request and does not drive `wake_o`.
- R11: Lines are independent. An edge on one line sets only that line's flag bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | Raw external interrupt pins |
| mode_i | input | 8 | Sense mode, 2 bits per line |
| en_i | input | 4 | Per-line enable |
| clk_io_en_i | input | 1 | I/O clock running; qualifies edge recognition |
| flag_clr_i | input | 4 | Write-one-to-clear strobes for the flags |
| flag_o | output | 4 | Sticky edge flags |
| req_o | output | 4 | Per-line interrupt requests |
| wake_o | output | 1 | Asynchronous level-mode wake |

## Verification
Several properties are checked on every cycle by the assertions:
- a flag holds until it is cleared;
- no flag rises while the clock-enable is low or the line is in level mode;
- a disabled line or a reserved-mode line never requests.

Some behaviour needs the bench's directed scenarios instead, because it depends on exact sequences rather than single-cycle relations:
- the three-edge edge latency and the two-edge level latency;
- set winning over a clear on the same edge;
- an edge lost while the clock-enable was low;
- the short low pulse that wakes with the clock stopped but leaves no request.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_NONE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_sync_i,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  input  logic       io_en_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       req_o
);
  logic prev_q, flag_q;
  logic fell, rose, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_sync_i;
  end

  assign fell = prev_q & ~pin_sync_i;
  assign rose = ~prev_q & pin_sync_i;

  always_comb begin
    hit = 1'b0;
    if (io_en_i && en_i) begin
      unique case (mode_i)
        SENSE_FALL: hit = fell;
        SENSE_RISE: hit = rose;
        default:    hit = 1'b0;
      endcase
    end
  end

  // set has priority over a write-one-to-clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= hit | (flag_q & ~clr_i);
  end

  always_comb begin
    req_o = 1'b0;
    if (en_i) begin
      unique case (mode_i)
        SENSE_LOW:              req_o = ~pin_sync_i;
        SENSE_FALL, SENSE_RISE: req_o = flag_q;
        default:                req_o = 1'b0;
      endcase
    end
  end

  assign flag_o = flag_q;

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  a_r6_no_edge_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_en_i && !flag_q) |=> !flag_q);
  a_r7_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_LOW && !flag_q) |=> !flag_q);
  a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_NONE) |-> !req_o);
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !req_o);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int MODE_W     = 2 * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic [NUM_LINES-1:0] en_i,
  input  logic                 clk_io_en_i,
  input  logic [NUM_LINES-1:0] flag_clr_i,
  output logic [NUM_LINES-1:0] flag_o,
  output logic [NUM_LINES-1:0] req_o,
  output logic                 wake_o
);
  logic [NUM_LINES-1:0] pin_sync;
  logic [NUM_LINES-1:0] lvl_wake;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    ext_irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_i[i]),
      .sync_o  (pin_sync[i])
    );

    ext_irq_line u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_sync_i (pin_sync[i]),
      .mode_i     (mode_i[2*i +: 2]),
      .en_i       (en_i[i]),
      .io_en_i    (clk_io_en_i),
      .clr_i      (flag_clr_i[i]),
      .flag_o     (flag_o[i]),
      .req_o      (req_o[i])
    );

    // clockless path: raw pin, no register
    assign lvl_wake[i] = en_i[i] && (mode_i[2*i +: 2] == SENSE_LOW) && !pin_i[i];
  end

  assign wake_o = |lvl_wake;

  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flag_o == '0));
endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic [3:0] pin_i = 4'hF;
  logic [7:0] mode_i = 8'h55;
  logic [3:0] en_i = 4'h0;
  logic       clk_io_en_i = 1'b1;
  logic [3:0] flag_clr_i = 4'h0;
  logic [3:0] flag_o, req_o;
  logic       wake_o;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always begin
    #2.5;
    if (clk_run || clk) clk = ~clk;
  end

  ext_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mode_i(mode_i), .en_i(en_i),
    .clk_io_en_i(clk_io_en_i), .flag_clr_i(flag_clr_i),
    .flag_o(flag_o), .req_o(req_o), .wake_o(wake_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input int ln, input logic [1:0] m);
    mode_i[2*ln +: 2] = m;
  endtask

  task automatic clear_flags(input logic [3:0] m);
    @(negedge clk) flag_clr_i = m;
    @(negedge clk) flag_clr_i = 4'h0;
    #1;
  endtask

  task automatic t_reset();
    edges(1);
    check("R1 flags in reset", flag_o, 0);
    check("R1 req in reset", req_o, 0);
    @(negedge clk) rst_n = 1'b1;
    edges(1);
    check("R1 flags after reset", flag_o, 0);
  endtask

  task automatic t_falling();
    @(negedge clk); set_mode(0, 2'b10); en_i[0] = 1'b1; pin_i[0] = 1'b0;
    edges(2);
    check("R3 flag not yet at edge2", flag_o[0], 0);
    edges(1);
    check("R3 flag at edge3", flag_o[0], 1);
    check("R3 req edge", req_o[0], 1);
    check("R11 only line0", flag_o, 4'b0001);
    @(negedge clk) pin_i[0] = 1'b1;
    edges(4);
    check("R5 sticky", flag_o[0], 1);
    clear_flags(4'b0001);
    check("R5 w1c", flag_o[0], 0);
    edges(3);
    check("R3 rise ignored", flag_o[0], 0);
  endtask

  task automatic t_rising();
    @(negedge clk); set_mode(1, 2'b11); en_i[1] = 1'b1; pin_i[1] = 1'b0;
    edges(4);
    check("R4 fall ignored", flag_o[1], 0);
    @(negedge clk) pin_i[1] = 1'b1;
    edges(2);
    check("R4 not yet", flag_o[1], 0);
    edges(1);
    check("R4 rise sets", flag_o[1], 1);
    clear_flags(4'b0010);
    check("R5 clear line1", flag_o[1], 0);
  endtask

  task automatic t_set_wins();
    @(negedge clk); set_mode(2, 2'b10); en_i[2] = 1'b1; pin_i[2] = 1'b0;
    edges(2);
    flag_clr_i = 4'b0100;
    edges(1);
    flag_clr_i = 4'b0000;
    check("R5 set beats clear", flag_o[2], 1);
    clear_flags(4'b0100);
    check("R5 clear line2", flag_o[2], 0);
    @(negedge clk) pin_i[2] = 1'b1;
    edges(4);
  endtask

  task automatic t_halt();
    @(negedge clk); clk_io_en_i = 1'b0; pin_i[0] = 1'b0;
    edges(5);
    @(negedge clk) clk_io_en_i = 1'b1;
    edges(3);
    check("R6 edge lost while halted", flag_o[0], 0);
    @(negedge clk) pin_i[0] = 1'b1;
    edges(4);
    @(negedge clk) pin_i[0] = 1'b0;
    edges(4);
    check("R6 edge seen when running", flag_o[0], 1);
    clear_flags(4'b0001);
    @(negedge clk) pin_i[0] = 1'b1;
    edges(4);
  endtask

  task automatic t_level();
    @(negedge clk); set_mode(3, 2'b00); en_i[3] = 1'b1; pin_i[3] = 1'b0;
    #1;
    check("R8 wake immediate", wake_o, 1);
    edges(1);
    check("R7 req not yet", req_o[3], 0);
    edges(1);
    check("R7 req asserted", req_o[3], 1);
    edges(6);
    check("R7 req held while low", req_o[3], 1);
    check("R7 no flag", flag_o[3], 0);
    @(negedge clk) pin_i[3] = 1'b1;
    #1;
    check("R8 wake drops", wake_o, 0);
    edges(1);
    check("R7 req still up", req_o[3], 1);
    edges(1);
    check("R7 req released", req_o[3], 0);
  endtask

  task automatic t_wake_no_clk();
    @(negedge clk) clk_run = 1'b0;
    #20 pin_i[3] = 1'b0;
    #20 check("R8 wake with clock stopped", wake_o, 1);
    pin_i[3] = 1'b1;
    #10 check("R9 wake released", wake_o, 0);
    clk_run = 1'b1;
    edges(5);
    check("R9 no request left", req_o[3], 0);
    check("R9 no flag left", flag_o[3], 0);
  endtask

  task automatic t_reserved();
    @(negedge clk); set_mode(1, 2'b01); pin_i[1] = 1'b0;
    #1 check("R2 reserved no wake", wake_o, 0);
    edges(4);
    @(negedge clk) pin_i[1] = 1'b1;
    edges(4);
    check("R2 reserved no flag", flag_o[1], 0);
    check("R2 reserved no req", req_o[1], 0);
  endtask

  task automatic t_disabled();
    @(negedge clk); en_i[2] = 1'b0; set_mode(2, 2'b10); pin_i[2] = 1'b0;
    edges(4);
    check("R10 disabled no flag", flag_o[2], 0);
    check("R10 disabled no req", req_o[2], 0);
    @(negedge clk) set_mode(2, 2'b00);
    #1 check("R10 disabled no wake", wake_o, 0);
    edges(3);
    check("R10 disabled level no req", req_o[2], 0);
    @(negedge clk) pin_i[2] = 1'b1;
    edges(3);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_falling();
    t_rising();
    t_set_wins();
    t_halt();
    t_level();
    t_wake_no_clk();
    t_reserved();
    t_disabled();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule